// File: doc/BRIEF.md
# Flexible Power-Up Sequencer

This block turns a set of resource enables (regulators, general-purpose output enables, a reset line) on and off in a programmed order. Three master timers each watch a trigger: one of two hardware enable pins or a software bit. When a timer's trigger rises, it runs an up sequence of eight evenly spaced event slots numbered 0 to 7. When the trigger falls, it runs a down sequence through the same eight slots. The spacing of the slots is set per timer as a power-of-two multiple of a base period, counted in clock-enable ticks.

Each resource has its own slave configuration. The configuration names the resource's enable source: one of the timers, or a direct software bit. It also gives a power-up slot and a power-down slot. A resource that follows a timer turns on at its power-up slot in an up sequence and turns off at its power-down slot in a down sequence. If a trigger changes while its sequence is still running, the timer drops that sequence and starts the opposite one from slot 0. A global sleep mode, together with an external sleep trigger, forces low every resource that is marked for sleep. The resource's own state is kept while it is forced low.

Top module: `fps_sequencer`

## Requirements
- R1: After reset every resource enable is low and every timer is idle.
- R2: The 2-bit timer select picks the trigger as follows. Value 0 selects `hw_en_i[0]` and value 1 selects `hw_en_i[1]`. Values 2 and 3 select that timer's bit in `tmr_sw_i`.
- R3: A rising trigger starts an up sequence and a falling trigger starts a down sequence. Each sequence emits slots 0 to 7 in ascending order, and the timer then goes idle.
- R4: The slot period is P = BASE_TICKS << code, where code is the timer's 3-bit period field. Assume `tick_i` is held high and count the clock edges from the edge that first samples the trigger change, counting that edge as 1. A resource whose slot is k then changes its enable at edge (k+1)*P+2.
- R5: The resource source field is `$clog2(N_TMR+1)` bits wide. Values 0 to N_TMR-1 name a timer, and the value N_TMR selects software mode. A resource ignores every event from timers it does not name.
- R6: A resource that follows a timer turns on at its 3-bit power-up slot in an up sequence. It turns off at its 3-bit power-down slot in a down sequence.
- R7: A resource in software mode takes the value of its `res_sw_i` bit one clock edge later and ignores every timer event.
- R8: A trigger change during a running sequence abandons that sequence. The timer then starts the opposite sequence from slot 0, so up slots that had not yet been reached never fire.
- R9: Suppose `slp_mode_i`, `sleep_i` and the resource's `res_slp_i` bit are all high. The enable is then low from the next edge on. When the condition clears, the enable returns to the kept state one edge later. While `slp_mode_i` is low, `sleep_i` has no effect.
- R10: Slot counting advances only on clock edges where `tick_i` is high. If `tick_i` is raised while a sequence is already pending, a slot-k resource changes at the edge (k+1)*P+1, counting the first edge that samples the tick as edge 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Clock enable for slot timing |
| hw_en_i | input | 2 | Hardware enable pins |
| tmr_sel_i | input | 2*N_TMR | Trigger select for each timer |
| tmr_sw_i | input | N_TMR | Software trigger bit for each timer |
| tmr_per_i | input | 3*N_TMR | Slot period code for each timer |
| res_src_i | input | SRC_W*N_RES | Enable source for each resource |
| res_sw_i | input | N_RES | Software enable bit for each resource |
| res_pu_i | input | 3*N_RES | Power-up slot for each resource |
| res_pd_i | input | 3*N_RES | Power-down slot for each resource |
| res_slp_i | input | N_RES | Sleep participation for each resource |
| slp_mode_i | input | 1 | Global sleep mode enable |
| sleep_i | input | 1 | External sleep trigger |
| res_en_o | output | N_RES | Resource enable outputs |

## Verification
The bench builds the block with N_RES=4, N_TMR=3 and BASE_TICKS=1, so the slot periods 1, 2 and 4 are short enough to sweep every slot under each of them. Across the sweep every timer and every trigger-select value is used, with three resources on the active timer and a fourth on an idle timer. This makes the arrival edge of every power-up and power-down slot a closed-form number. The short periods also make it cheap to land a trigger reversal in the middle of a sequence, to hold the tick low, and to exercise sleep gating.

// File: rtl/fps_pkg.sv
package fps_pkg;

  localparam int unsigned SLOTS = 8;

  // ticks between two consecutive slots of a timer
  function automatic int unsigned slot_period(input logic [2:0] code,
                                              input int unsigned base);
    return base << code;
  endfunction

  // trigger level seen by a timer: select bit 1 high -> software bit
  function automatic logic pick_trigger(input logic [1:0] sel,
                                        input logic [1:0] hw,
                                        input logic       sw);
    return sel[1] ? sw : hw[sel[0]];
  endfunction

endpackage

// File: rtl/fps_master_timer.sv
module fps_master_timer #(
  parameter int unsigned BASE_TICKS = 4,
  parameter int unsigned CNT_W      = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       trig_i,
  input  logic [2:0] per_code_i,
  output logic       evt_o,
  output logic [2:0] evt_idx_o,
  output logic       evt_dir_o,
  output logic       busy_o,
  output logic       edge_o,
  output logic [2:0] seq_idx_o
);

  logic             lvl_q, busy_q, dir_q;
  logic [2:0]       idx_q;
  logic [CNT_W-1:0] cnt_q, per_m1;

  assign per_m1 = CNT_W'(fps_pkg::slot_period(per_code_i, BASE_TICKS) - 1);
  assign edge_o = trig_i ^ lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q     <= 1'b0;
      busy_q    <= 1'b0;
      dir_q     <= 1'b0;
      idx_q     <= '0;
      cnt_q     <= '0;
      evt_o     <= 1'b0;
      evt_idx_o <= '0;
      evt_dir_o <= 1'b0;
    end else begin
      evt_o <= 1'b0;
      if (edge_o) begin
        lvl_q  <= trig_i;
        busy_q <= 1'b1;
        dir_q  <= trig_i;
        idx_q  <= '0;
        cnt_q  <= '0;
      end else if (busy_q && tick_i) begin
        if (cnt_q == per_m1) begin
          evt_o     <= 1'b1;
          evt_idx_o <= idx_q;
          evt_dir_o <= dir_q;
          cnt_q     <= '0;
          if (idx_q == 3'd7) busy_q <= 1'b0;
          else               idx_q  <= idx_q + 3'd1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign seq_idx_o = idx_q;

endmodule

// File: rtl/fps_slave.sv
module fps_slave #(
  parameter int unsigned N_TMR = 3,
  parameter int unsigned SRC_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SRC_W-1:0]     src_i,
  input  logic                 sw_i,
  input  logic [2:0]           pu_i,
  input  logic [2:0]           pd_i,
  input  logic                 slp_en_i,
  input  logic                 slp_act_i,
  input  logic [N_TMR-1:0]     evt_i,
  input  logic [3*N_TMR-1:0]   evt_idx_i,
  input  logic [N_TMR-1:0]     evt_dir_i,
  output logic                 state_o,
  output logic                 en_o
);

  logic hit_on, hit_off, sw_mode, gate_q;

  assign sw_mode = (src_i >= SRC_W'(N_TMR));

  always_comb begin
    hit_on  = 1'b0;
    hit_off = 1'b0;
    for (int t = 0; t < N_TMR; t++) begin
      if (src_i == SRC_W'(t) && evt_i[t]) begin
        if (evt_dir_i[t]  && evt_idx_i[3*t +: 3] == pu_i) hit_on  = 1'b1;
        if (!evt_dir_i[t] && evt_idx_i[3*t +: 3] == pd_i) hit_off = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_o <= 1'b0;
      gate_q  <= 1'b0;
    end else begin
      gate_q <= slp_act_i & slp_en_i;
      if (sw_mode)      state_o <= sw_i;
      else if (hit_on)  state_o <= 1'b1;
      else if (hit_off) state_o <= 1'b0;
    end
  end

  assign en_o = state_o & ~gate_q;

endmodule

// File: rtl/fps_sequencer.sv
module fps_sequencer #(
  parameter int unsigned N_RES      = 8,
  parameter int unsigned N_TMR      = 3,
  parameter int unsigned BASE_TICKS = 4,
  localparam int unsigned SRC_W     = $clog2(N_TMR + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick_i,
  input  logic [1:0]               hw_en_i,
  input  logic [2*N_TMR-1:0]       tmr_sel_i,
  input  logic [N_TMR-1:0]         tmr_sw_i,
  input  logic [3*N_TMR-1:0]       tmr_per_i,
  input  logic [SRC_W*N_RES-1:0]   res_src_i,
  input  logic [N_RES-1:0]         res_sw_i,
  input  logic [3*N_RES-1:0]       res_pu_i,
  input  logic [3*N_RES-1:0]       res_pd_i,
  input  logic [N_RES-1:0]         res_slp_i,
  input  logic                     slp_mode_i,
  input  logic                     sleep_i,
  output logic [N_RES-1:0]         res_en_o
);

  localparam int unsigned CNT_W = $clog2(BASE_TICKS * 128) + 1;

  // named internal events, used by the bound checker
  logic [N_TMR-1:0]   tmr_trig, tmr_evt, tmr_dir, tmr_busy, tmr_edge;
  logic [3*N_TMR-1:0] tmr_evt_idx, tmr_seq_idx;
  logic [N_RES-1:0]   res_state;
  logic               slp_act;

  assign slp_act = slp_mode_i & sleep_i;

  for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
    assign tmr_trig[t] = fps_pkg::pick_trigger(tmr_sel_i[2*t +: 2], hw_en_i, tmr_sw_i[t]);

    fps_master_timer #(.BASE_TICKS(BASE_TICKS), .CNT_W(CNT_W)) u_tmr (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick_i),
      .trig_i     (tmr_trig[t]),
      .per_code_i (tmr_per_i[3*t +: 3]),
      .evt_o      (tmr_evt[t]),
      .evt_idx_o  (tmr_evt_idx[3*t +: 3]),
      .evt_dir_o  (tmr_dir[t]),
      .busy_o     (tmr_busy[t]),
      .edge_o     (tmr_edge[t]),
      .seq_idx_o  (tmr_seq_idx[3*t +: 3])
    );
  end

  for (genvar r = 0; r < N_RES; r++) begin : g_res
    fps_slave #(.N_TMR(N_TMR), .SRC_W(SRC_W)) u_slv (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_i     (res_src_i[SRC_W*r +: SRC_W]),
      .sw_i      (res_sw_i[r]),
      .pu_i      (res_pu_i[3*r +: 3]),
      .pd_i      (res_pd_i[3*r +: 3]),
      .slp_en_i  (res_slp_i[r]),
      .slp_act_i (slp_act),
      .evt_i     (tmr_evt),
      .evt_idx_i (tmr_evt_idx),
      .evt_dir_i (tmr_dir),
      .state_o   (res_state[r]),
      .en_o      (res_en_o[r])
    );
  end

endmodule

// File: rtl/fps_sequencer_chk.sv
module fps_sequencer_chk #(
  parameter int unsigned N_RES = 8,
  parameter int unsigned N_TMR = 3,
  parameter int unsigned SRC_W = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   tick_i,
  input logic [SRC_W*N_RES-1:0] res_src_i,
  input logic [N_RES-1:0]       res_sw_i,
  input logic [N_RES-1:0]       res_slp_i,
  input logic                   slp_mode_i,
  input logic                   sleep_i,
  input logic [N_RES-1:0]       res_en_o,
  input logic [N_TMR-1:0]       tmr_evt,
  input logic [N_TMR-1:0]       tmr_busy,
  input logic [N_TMR-1:0]       tmr_edge,
  input logic [3*N_TMR-1:0]     tmr_seq_idx,
  input logic [N_RES-1:0]       res_state
);

  for (genvar t = 0; t < N_TMR; t++) begin : g_t
    a_r10_event_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_evt[t] |-> $past(tick_i));
    a_r3_event_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_evt[t] |-> $past(tmr_busy[t]));
    a_r8_restart_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_edge[t] |=> (tmr_busy[t] && tmr_seq_idx[3*t +: 3] == 3'd0));
  end

  for (genvar r = 0; r < N_RES; r++) begin : g_r
    a_r7_software_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (res_src_i[SRC_W*r +: SRC_W] >= SRC_W'(N_TMR)) |=> res_state[r] == $past(res_sw_i[r]));
    a_r9_sleep_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
      (slp_mode_i && sleep_i && res_slp_i[r]) |=> !res_en_o[r]);
    a_r9_awake_shows_state: assert property (@(posedge clk) disable iff (!rst_n)
      !(slp_mode_i && sleep_i && res_slp_i[r]) |=> res_en_o[r] == res_state[r]);
  end

endmodule

bind fps_sequencer fps_sequencer_chk #(.N_RES(N_RES), .N_TMR(N_TMR), .SRC_W(SRC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .res_src_i(res_src_i), .res_sw_i(res_sw_i),
  .res_slp_i(res_slp_i), .slp_mode_i(slp_mode_i), .sleep_i(sleep_i), .res_en_o(res_en_o),
  .tmr_evt(tmr_evt), .tmr_busy(tmr_busy), .tmr_edge(tmr_edge), .tmr_seq_idx(tmr_seq_idx),
  .res_state(res_state)
);

// File: tb/sim_fps_sequencer.sv
module sim_fps_sequencer;
  localparam int NR = 4, NT = 3, SW = 2;

  logic clk = 0, rst_n = 0, tick_i = 1, slp_mode_i = 0, sleep_i = 0;
  logic [1:0]       hw_en_i = '0;
  logic [2*NT-1:0]  tmr_sel_i = '1;
  logic [NT-1:0]    tmr_sw_i = '0;
  logic [3*NT-1:0]  tmr_per_i = '0;
  logic [SW*NR-1:0] res_src_i = '0;
  logic [NR-1:0]    res_sw_i = '0, res_slp_i = '0;
  logic [3*NR-1:0]  res_pu_i = '0, res_pd_i = '0;
  logic [NR-1:0]    res_en_o;

  int checks = 0, errors = 0, chg [NR];
  logic [NR-1:0] prev;

  always #5 clk = ~clk;

  fps_sequencer #(.N_RES(NR), .N_TMR(NT), .BASE_TICKS(1)) u0 (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // record, per resource, the first edge count at which its enable changed
  task automatic measure(input int limit);
    prev = res_en_o;
    for (int r = 0; r < NR; r++) chg[r] = 0;
    for (int c = 1; c <= limit; c++) begin
      @(posedge clk); @(negedge clk);
      for (int r = 0; r < NR; r++)
        if (chg[r] == 0 && res_en_o[r] != prev[r]) chg[r] = c;
    end
  endtask

  task automatic drive_trig(input int t, input int sel, input logic v);
    if (sel == 0)      hw_en_i[0]  = v;
    else if (sel == 1) hw_en_i[1]  = v;
    else               tmr_sw_i[t] = v;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int p, t, sel;
    cycles(3);
    check(res_en_o == '0, "R1 outputs low in reset", res_en_o, 0);
    rst_n = 1;
    cycles(2);
    check(res_en_o == '0, "R1 outputs low after reset", res_en_o, 0);

    // sweep: period codes x base slot, all trigger selects and timers
    for (int code = 0; code < 3; code++) begin
      for (int b = 0; b < 8; b++) begin
        p = 1 << code; t = b % 3; sel = b % 4;
        tmr_sel_i = '1; tmr_sw_i = '0;
        tmr_sel_i[2*t +: 2] = 2'(sel);
        tmr_per_i[3*t +: 3] = 3'(code);
        for (int r = 0; r < 3; r++) begin
          res_src_i[SW*r +: SW] = 2'(t);
          res_pu_i[3*r +: 3] = 3'((b + 3*r) % 8);
          res_pd_i[3*r +: 3] = 3'((7 - b + 2*r) % 8);
        end
        res_src_i[SW*3 +: SW] = 2'((t + 1) % 3);
        cycles(2);
        drive_trig(t, sel, 1'b1);
        measure(8*p + 4);
        for (int r = 0; r < 3; r++)
          check(chg[r] == ((b + 3*r) % 8 + 1)*p + 2, "R4 R6 R2 power-up slot timing",
                chg[r], ((b + 3*r) % 8 + 1)*p + 2);
        check(chg[3] == 0, "R5 other timer ignored (up)", chg[3], 0);
        drive_trig(t, sel, 1'b0);
        measure(8*p + 4);
        for (int r = 0; r < 3; r++)
          check(chg[r] == ((7 - b + 2*r) % 8 + 1)*p + 2, "R3 R6 power-down slot timing",
                chg[r], ((7 - b + 2*r) % 8 + 1)*p + 2);
        check(chg[3] == 0, "R5 other timer ignored (down)", chg[3], 0);
      end
    end

    // R8: reversal mid-sequence, R7: software resource ignores events
    tmr_sel_i = '1; tmr_sw_i = '0; tmr_per_i = '0;
    tmr_per_i[2:0] = 3'd1;
    res_src_i = '0; res_src_i[SW*2 +: SW] = 2'd3;
    res_pu_i = '0; res_pd_i = '0;
    res_pu_i[2:0] = 3'd1; res_pu_i[5:3] = 3'd6;
    cycles(2);
    tmr_sw_i[0] = 1'b1;
    measure(7);
    check(res_en_o[0] == 1'b1, "R8 slot1 on before reversal", res_en_o[0], 1);
    check(res_en_o[1] == 1'b0, "R8 slot6 not yet on", res_en_o[1], 0);
    tmr_sw_i[0] = 1'b0;
    measure(24);
    check(chg[0] == 4, "R8 down restarts at slot 0", chg[0], 4);
    check(chg[1] == 0, "R8 abandoned up slot never fires", chg[1], 0);
    check(chg[2] == 0, "R7 software resource ignores events", chg[2], 0);

    res_sw_i[2] = 1'b1;
    #1 check(res_en_o[2] == 1'b0, "R7 no change before edge", res_en_o[2], 0);
    cycles(1);
    check(res_en_o[2] == 1'b1, "R7 follows bit after one edge", res_en_o[2], 1);

    // R9: sleep gating, resources 0 and 1 in software mode, both on
    res_src_i[1:0] = 2'd3; res_src_i[3:2] = 2'd3; res_sw_i[1:0] = 2'b11;
    res_slp_i = 4'b0001;
    cycles(2);
    sleep_i = 1'b1;
    cycles(3);
    check(res_en_o[0] == 1'b1, "R9 sleep trigger ignored in normal mode", res_en_o[0], 1);
    slp_mode_i = 1'b1;
    #1 check(res_en_o[0] == 1'b1, "R9 not gated before edge", res_en_o[0], 1);
    cycles(1);
    check(res_en_o[0] == 1'b0, "R9 sleeping resource off", res_en_o[0], 0);
    check(res_en_o[1] == 1'b1, "R9 non-sleep resource stays on", res_en_o[1], 1);
    sleep_i = 1'b0;
    cycles(1);
    check(res_en_o[0] == 1'b1, "R9 state restored on wake", res_en_o[0], 1);
    slp_mode_i = 1'b0;

    // R10: held tick stalls the sequence
    res_sw_i = '0;
    cycles(2);
    res_src_i = '0; res_pu_i = '0; tmr_per_i = '0;
    cycles(2);
    tick_i = 1'b0;
    tmr_sw_i[0] = 1'b1;
    measure(20);
    check(chg[0] == 0, "R10 no slot without tick", chg[0], 0);
    tick_i = 1'b1;
    measure(6);
    check(chg[0] == 2, "R10 slot timing counts ticks", chg[0], 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule